// File: doc/BRIEF.md
# Dual-Channel Hot-Swap Supervisory Sequencer

This block is the digital controller that sits between two hot-swap power channels and their analog front ends. Each channel has digital comparator flags for its on request, a detach input, under- and overvoltage, active current limit, feedback above threshold and gate fully enhanced. The block turns each channel's gate on through a start-up timing phase and qualifies power-good. It turns a channel off for any of the normal or fault causes, latches faults per channel, and asks for a fast gate pulldown when a supply rail dips for too long.

Software sees a small write port. Per channel, a control word holds a software enable and three auto-retry bits. A fault word reflects undervoltage, overvoltage and overcurrent events and can be overwritten. A mode input chooses whether an overcurrent fault stops only the faulting channel or both channels. All durations are counted in clock cycles, and their defaults are parameters.

Top module: `hotswap_seq`

## Requirements
- R1: A channel whose start conditions hold (on high, software enable set, detach low, no UV or OV, no trip, no latched fault) drives gate_on the next cycle and enters start-up. Start-up ends once its counter reaches TMR_FIXED_CYC clock cycles when tmr_fixed_sel is 1, or TMR_TICKS tmr_tick pulses when tmr_fixed_sel is 0.
- R2: pgood rises only while the channel is past start-up with both fb_ok and gate_enh high. It is cleared when fb_ok is low, including after turn-off, and it is cleared when start-up begins again.
- R3: The gate turns off the cycle after on goes low, or after a control write clears the software enable (control word bit 0).
- R4: The gate turns off on ch_uv, on ch_ov, or on a rising edge of ch_detach. While on is high, UV sets fault bit 0 and OV sets fault bit 1.
- R5: Current limit while running, or still active at the end of start-up, sets fault bit 2 and turns the gate off. If current limit clears before start-up ends, no fault is raised.
- R6: When oc_single_mode is 0, an overcurrent event on either channel turns off both gates. The other channel is also held off while the faulting channel's bit 2 is set with its retry off.
- R7: A fault bit whose auto-retry bit is 0 keeps the channel off. The control word bits 3:1 are the retry bits for OC, OV and UV in that order (bit 3 OC, bit 1 UV). The reset value is UV and OV retry on, OC retry off, with software enable set.
- R8: A write to a fault word (wr_addr bit 0 = 1, wr_addr bit 1 = channel) replaces bits 2:0 with wr_data[2:0]. Writing a 1 whose retry is off turns the gate off; writing 0 lets the channel restart.
- R9: A high-to-low transition of on clears that channel's fault word.
- R10: fast_pd rises when core_ok is low for more than CORE_DG_CYC consecutive cycles (both channels), or when vdd_ok[i] is low for more than VDD_DG_CYC consecutive cycles (channel i only). The gate then turns off. Shorter dips have no effect.
- R11: After reset all gates, pgood, fast_pd and fault bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_on | input | 2 | Per-channel on request |
| ch_detach | input | 2 | Per-channel detach flag; rising edge turns off |
| ch_uv | input | 2 | Undervoltage comparator |
| ch_ov | input | 2 | Overvoltage comparator |
| ch_ilim | input | 2 | Current limit active |
| ch_fb_ok | input | 2 | Feedback above threshold |
| ch_gate_enh | input | 2 | Gate fully enhanced |
| vdd_ok | input | 2 | Per-channel input supply above its low limit |
| core_ok | input | 1 | Internal supply above its low limit |
| oc_single_mode | input | 1 | 1: overcurrent stops only its channel; 0: both |
| tmr_tick | input | 1 | Start-up timer tick pulse |
| tmr_fixed_sel | input | 1 | 1: fixed-cycle start-up duration |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Bit 1 channel, bit 0 fault(1)/control(0) |
| wr_data | input | 4 | Write data |
| gate_on | output | 2 | Gate drive enable |
| fast_pd | output | 2 | Fast gate pulldown request |
| pgood | output | 2 | Power good |
| ch_fault | output | 6 | Fault words, channel 0 in bits 2:0 |

## Verification
The assertions check on every cycle that a gate is never on without its on request in the prior cycle, and that pgood rises only after feedback, enhancement and gate drive were all present. They also check that pgood never survives a low feedback, that UV always records its bit, and that a fast pulldown always removes the gate. The start-up length in both timer modes, overcurrent at timer expiry versus overcurrent that clears early, coupling across channels in dual mode, latching by retry bit, fault clearing by software and by cycling on, and the deglitch lengths are shown only by the bench scenarios. In those scenarios a behavioural model is compared against the design on every clock.

// File: rtl/hs_pkg.sv
// Shared types and constants for the hot-swap sequencer.
// Assumes two channels and a three-bit fault word per channel.
package hs_pkg;
    localparam int NCH  = 2;
    localparam int NFLT = 3;
    localparam int FLT_UV = 0;
    localparam int FLT_OV = 1;
    localparam int FLT_OC = 2;
    localparam int WR_W = 4;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_START = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_t;
endpackage

// File: rtl/hs_lowflt.sv
// Supply-low deglitch: counts consecutive cycles with ok low and raises
// trip once the count exceeds DG_CYC. Assumes ok is already synchronous.
module hs_lowflt #(
    parameter int DG_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok,
    output logic trip
);
    localparam int CW = $clog2(DG_CYC + 2);
    localparam logic [CW-1:0] LIM = CW'(DG_CYC + 1);

    logic [CW-1:0] cnt;

    // Saturating count of consecutive low samples.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (ok)       cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign trip = (cnt == LIM);
endmodule

// File: rtl/hs_sutimer.sv
// Start-up timer: while run is high it counts either clock cycles (fixed
// mode) or tick pulses up to the selected limit; expired flags the limit.
// Assumes fixed_sel is stable during a start-up.
module hs_sutimer #(
    parameter int TMR_TICKS     = 100,
    parameter int TMR_FIXED_CYC = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fixed_sel,
    input  logic tick,
    output logic expired
);
    localparam int TMAX = (TMR_TICKS > TMR_FIXED_CYC) ? TMR_TICKS : TMR_FIXED_CYC;
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          step;

    // Select the limit and the counting event.
    always_comb begin
        lim  = fixed_sel ? CW'(TMR_FIXED_CYC) : CW'(TMR_TICKS);
        step = fixed_sel | tick;
    end

    // Count while in start-up, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (!run)                cnt <= '0;
        else if (step && (cnt < lim)) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == lim);
endmodule

// File: rtl/hs_chan.sv
// One channel: idle/start-up/run state machine, fault word, control word
// and power-good qualification. Assumes comparator flags are synchronous
// and that the peer coupling terms come from the top level.
module hs_chan
    import hs_pkg::*;
#(
    parameter int TMR_TICKS     = 100,
    parameter int TMR_FIXED_CYC = 20_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            on,
    input  logic            detach,
    input  logic            uv,
    input  logic            ov,
    input  logic            ilim,
    input  logic            fb_ok,
    input  logic            gate_enh,
    input  logic            trip,
    input  logic            tmr_fixed,
    input  logic            tmr_tick,
    input  logic            ctrl_we,
    input  logic            fault_we,
    input  logic [WR_W-1:0] wr_data,
    input  logic            peer_kill,
    input  logic            peer_hold,
    output logic            gate_on,
    output logic            pgood,
    output logic [NFLT-1:0] fault,
    output logic [NFLT-1:0] retry,
    output logic            oc_evt
);
    ch_state_t       st, st_nx;
    logic [NFLT-1:0] flt_q, flt_nx, flt_base, flt_evt;
    logic [NFLT-1:0] retry_q;
    logic            swen_q, on_q, det_q, pg_q;
    logic            tmr_exp, hold, kill, start_ok, det_rise, on_fall;

    hs_sutimer #(
        .TMR_TICKS     (TMR_TICKS),
        .TMR_FIXED_CYC (TMR_FIXED_CYC)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st == CH_START),
        .fixed_sel (tmr_fixed),
        .tick      (tmr_tick),
        .expired   (tmr_exp)
    );

    // Turn-off and start qualification terms.
    always_comb begin
        oc_evt   = ilim & ((st == CH_RUN) | tmr_exp);
        hold     = |(flt_q & ~retry_q);
        det_rise = detach & ~det_q;
        on_fall  = on_q & ~on;
        kill     = ~on | ~swen_q | det_rise | uv | ov | trip | hold
                 | peer_hold | oc_evt | peer_kill;
        start_ok = on & swen_q & ~detach & ~uv & ~ov & ~trip & ~hold & ~peer_hold;
    end

    // Next state of the channel sequence.
    always_comb begin
        st_nx = st;
        unique case (st)
            CH_IDLE:  if (start_ok) st_nx = CH_START;
            CH_START: if (kill) st_nx = CH_IDLE;
                      else if (tmr_exp) st_nx = CH_RUN;
            CH_RUN:   if (kill) st_nx = CH_IDLE;
            default:  st_nx = CH_IDLE;
        endcase
    end

    // Next fault word: clear on on-fall, software overwrite, then events.
    always_comb begin
        if (on_fall)       flt_base = '0;
        else if (fault_we) flt_base = wr_data[NFLT-1:0];
        else               flt_base = flt_q;
        flt_evt = '0;
        flt_evt[FLT_UV] = uv;
        flt_evt[FLT_OV] = ov;
        flt_evt[FLT_OC] = oc_evt;
        flt_nx = flt_base | (flt_evt & {NFLT{on}});
    end

    // State, fault and edge-detect registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= CH_IDLE;
            flt_q <= '0;
            on_q  <= 1'b0;
            det_q <= 1'b0;
        end else begin
            st    <= st_nx;
            flt_q <= flt_nx;
            on_q  <= on;
            det_q <= detach;
        end
    end

    // Control word: software enable in bit 0, retry bits above it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swen_q  <= 1'b1;
            retry_q <= 3'b011;
        end else if (ctrl_we) begin
            swen_q  <= wr_data[0];
            retry_q <= wr_data[NFLT:1];
        end
    end

    // Power-good qualification and release.
    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= 1'b0;
        else begin
            unique case (st)
                CH_RUN:   pg_q <= (pg_q | (fb_ok & gate_enh)) & fb_ok;
                CH_START: pg_q <= 1'b0;
                default:  pg_q <= pg_q & fb_ok;
            endcase
        end
    end

    assign gate_on = (st != CH_IDLE);
    assign pgood   = pg_q;
    assign fault   = flt_q;
    assign retry   = retry_q;
endmodule

// File: rtl/hotswap_seq.sv
// Top level: two channel controllers, supply-low deglitchers, write-port
// decode and cross-channel overcurrent coupling. Assumes all inputs are
// synchronous to clk.
module hotswap_seq
    import hs_pkg::*;
#(
    parameter int CORE_DG_CYC   = 200,
    parameter int VDD_DG_CYC    = 400,
    parameter int TMR_TICKS     = 100,
    parameter int TMR_FIXED_CYC = 20_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ch_on,
    input  logic [NCH-1:0]       ch_detach,
    input  logic [NCH-1:0]       ch_uv,
    input  logic [NCH-1:0]       ch_ov,
    input  logic [NCH-1:0]       ch_ilim,
    input  logic [NCH-1:0]       ch_fb_ok,
    input  logic [NCH-1:0]       ch_gate_enh,
    input  logic [NCH-1:0]       vdd_ok,
    input  logic                 core_ok,
    input  logic                 oc_single_mode,
    input  logic                 tmr_tick,
    input  logic                 tmr_fixed_sel,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [WR_W-1:0]      wr_data,
    output logic [NCH-1:0]       gate_on,
    output logic [NCH-1:0]       fast_pd,
    output logic [NCH-1:0]       pgood,
    output logic [NCH*NFLT-1:0]  ch_fault
);
    logic                 core_trip;
    logic [NCH-1:0]       vdd_trip, trip, oc_evt, ctrl_we, fault_we;
    logic [NCH-1:0]       peer_kill, peer_hold;
    logic [NFLT-1:0]      fault_w [NCH];
    logic [NFLT-1:0]      retry_w [NCH];

    hs_lowflt #(.DG_CYC(CORE_DG_CYC)) u_core_dg (
        .clk(clk), .rst_n(rst_n), .ok(core_ok), .trip(core_trip)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int P = NCH - 1 - c;

        hs_lowflt #(.DG_CYC(VDD_DG_CYC)) u_vdd_dg (
            .clk(clk), .rst_n(rst_n), .ok(vdd_ok[c]), .trip(vdd_trip[c])
        );

        // Per-channel decode of trips, writes and peer coupling.
        always_comb begin
            trip[c]      = core_trip | vdd_trip[c];
            ctrl_we[c]   = wr_en & (wr_addr[1] == c[0]) & ~wr_addr[0];
            fault_we[c]  = wr_en & (wr_addr[1] == c[0]) &  wr_addr[0];
            peer_kill[c] = ~oc_single_mode & oc_evt[P];
            peer_hold[c] = ~oc_single_mode & fault_w[P][FLT_OC] & ~retry_w[P][FLT_OC];
        end

        hs_chan #(
            .TMR_TICKS     (TMR_TICKS),
            .TMR_FIXED_CYC (TMR_FIXED_CYC)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .on        (ch_on[c]),
            .detach    (ch_detach[c]),
            .uv        (ch_uv[c]),
            .ov        (ch_ov[c]),
            .ilim      (ch_ilim[c]),
            .fb_ok     (ch_fb_ok[c]),
            .gate_enh  (ch_gate_enh[c]),
            .trip      (trip[c]),
            .tmr_fixed (tmr_fixed_sel),
            .tmr_tick  (tmr_tick),
            .ctrl_we   (ctrl_we[c]),
            .fault_we  (fault_we[c]),
            .wr_data   (wr_data),
            .peer_kill (peer_kill[c]),
            .peer_hold (peer_hold[c]),
            .gate_on   (gate_on[c]),
            .pgood     (pgood[c]),
            .fault     (fault_w[c]),
            .retry     (retry_w[c]),
            .oc_evt    (oc_evt[c])
        );

        assign ch_fault[c*NFLT +: NFLT] = fault_w[c];
        assign fast_pd[c] = trip[c];
    end
endmodule

// File: rtl/hs_seq_chk.sv
// Property checker for hotswap_seq, attached by bind below.
module hs_seq_chk
    import hs_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [NCH-1:0]      ch_on,
    input logic [NCH-1:0]      ch_uv,
    input logic [NCH-1:0]      ch_fb_ok,
    input logic [NCH-1:0]      ch_gate_enh,
    input logic [NCH-1:0]      gate_on,
    input logic [NCH-1:0]      fast_pd,
    input logic [NCH-1:0]      pgood,
    input logic [NCH*NFLT-1:0] ch_fault
);
    for (genvar c = 0; c < NCH; c++) begin : g_p
        p_gate_needs_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
            gate_on[c] |-> $past(ch_on[c]));
        p_pgood_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pgood[c]) |-> $past(ch_fb_ok[c] && ch_gate_enh[c] && gate_on[c]));
        p_pgood_needs_fb_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pgood[c] |-> $past(ch_fb_ok[c]));
        p_uv_records_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_on[c] && ch_uv[c]) |=> ch_fault[c*NFLT + FLT_UV]);
        p_fast_stops_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
            fast_pd[c] |=> !gate_on[c]);
    end
endmodule

bind hotswap_seq hs_seq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_on       (ch_on),
    .ch_uv       (ch_uv),
    .ch_fb_ok    (ch_fb_ok),
    .ch_gate_enh (ch_gate_enh),
    .gate_on     (gate_on),
    .fast_pd     (fast_pd),
    .pgood       (pgood),
    .ch_fault    (ch_fault)
);

// File: tb/test_hotswap_seq.sv
// Bench: behavioural per-clock reference model plus directed scenarios.
module test_hotswap_seq;
    localparam int CDG = 3, VDG = 5, TT = 4, TF = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] ch_on = '0, ch_detach = '0, ch_uv = '0, ch_ov = '0, ch_ilim = '0;
    logic [1:0] ch_fb_ok = '0, ch_gate_enh = '0, vdd_ok = 2'b11;
    logic       core_ok = 1'b1, oc_single_mode = 1'b1, tmr_tick = 1'b0, tmr_fixed_sel = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] gate_on, fast_pd, pgood;
    logic [5:0] ch_fault;

    int n_chk = 0, n_fail = 0;
    bit started = 0, done = 0;

    always #2.5 clk = ~clk;

    hotswap_seq #(.CORE_DG_CYC(CDG), .VDD_DG_CYC(VDG), .TMR_TICKS(TT), .TMR_FIXED_CYC(TF)) i_hotswap_seq (
        .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .ch_detach(ch_detach), .ch_uv(ch_uv),
        .ch_ov(ch_ov), .ch_ilim(ch_ilim), .ch_fb_ok(ch_fb_ok), .ch_gate_enh(ch_gate_enh),
        .vdd_ok(vdd_ok), .core_ok(core_ok), .oc_single_mode(oc_single_mode),
        .tmr_tick(tmr_tick), .tmr_fixed_sel(tmr_fixed_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .gate_on(gate_on), .fast_pd(fast_pd),
        .pgood(pgood), .ch_fault(ch_fault)
    );

    // Reference model state.
    int       m_st[2], m_cnt[2], m_core, m_vdd[2];
    bit       m_pg[2], m_swen[2], m_onq[2], m_detq[2];
    bit [2:0] m_flt[2], m_rty[2];

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model update on every clock edge.
    always @(posedge clk) begin
        int  nst[2], ncnt[2];
        bit  npg[2], trp[2], ex[2], oc[2];
        bit [2:0] nflt[2];
        bit  ctrip;
        int  lim;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_st[c] = 0; m_cnt[c] = 0; m_pg[c] = 0; m_swen[c] = 1;
                m_onq[c] = 0; m_detq[c] = 0; m_flt[c] = 0; m_rty[c] = 3'b011; m_vdd[c] = 0;
            end
            m_core = 0;
        end else begin
            ctrip = m_core > CDG;
            lim = tmr_fixed_sel ? TF : TT;
            for (int c = 0; c < 2; c++) begin
                trp[c] = ctrip || (m_vdd[c] > VDG);
                ex[c]  = (m_st[c] == 1) && (m_cnt[c] == lim);
                oc[c]  = ch_ilim[c] && ((m_st[c] == 2) || ex[c]);
            end
            for (int c = 0; c < 2; c++) begin
                int  p;
                bit  hold, phold, kill, sok;
                bit [2:0] base;
                p = 1 - c;
                hold  = |(m_flt[c] & ~m_rty[c]);
                phold = !oc_single_mode && m_flt[p][2] && !m_rty[p][2];
                kill  = !ch_on[c] || !m_swen[c] || (ch_detach[c] && !m_detq[c]) || ch_uv[c]
                      || ch_ov[c] || trp[c] || hold || phold || oc[c] || (!oc_single_mode && oc[p]);
                sok   = ch_on[c] && m_swen[c] && !ch_detach[c] && !ch_uv[c] && !ch_ov[c]
                      && !trp[c] && !hold && !phold;
                nst[c] = m_st[c];
                if (m_st[c] != 0 && kill) nst[c] = 0;
                else if (m_st[c] == 0 && sok) nst[c] = 1;
                else if (ex[c]) nst[c] = 2;
                if (m_st[c] == 1) ncnt[c] = (((tmr_fixed_sel || tmr_tick) && m_cnt[c] < lim) ? m_cnt[c] + 1 : m_cnt[c]);
                else ncnt[c] = 0;
                if (m_st[c] == 2) npg[c] = (m_pg[c] || (ch_fb_ok[c] && ch_gate_enh[c])) && ch_fb_ok[c];
                else if (m_st[c] == 1) npg[c] = 0;
                else npg[c] = m_pg[c] && ch_fb_ok[c];
                if (m_onq[c] && !ch_on[c]) base = 0;
                else if (wr_en && wr_addr == {c[0], 1'b1}) base = wr_data[2:0];
                else base = m_flt[c];
                nflt[c] = base | (ch_on[c] ? {oc[c], ch_ov[c], ch_uv[c]} : 3'b000);
            end
            for (int c = 0; c < 2; c++) begin
                if (wr_en && wr_addr == {c[0], 1'b0}) begin
                    m_swen[c] = wr_data[0]; m_rty[c] = wr_data[3:1];
                end
                m_st[c] = nst[c]; m_cnt[c] = ncnt[c]; m_pg[c] = npg[c]; m_flt[c] = nflt[c];
                m_onq[c] = ch_on[c]; m_detq[c] = ch_detach[c];
                m_vdd[c] = vdd_ok[c] ? 0 : ((m_vdd[c] > VDG) ? m_vdd[c] : m_vdd[c] + 1);
            end
            m_core = core_ok ? 0 : ((m_core > CDG) ? m_core : m_core + 1);
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (started && !done) begin
            for (int c = 0; c < 2; c++) begin
                chk(gate_on[c] == (m_st[c] != 0), "R1 gate_on vs model", gate_on[c], m_st[c] != 0);
                chk(pgood[c] == m_pg[c], "R2 pgood vs model", pgood[c], m_pg[c]);
                chk(ch_fault[c*3 +: 3] == m_flt[c], "R7 fault vs model", ch_fault[c*3 +: 3], m_flt[c]);
                chk(fast_pd[c] == ((m_core > CDG) || (m_vdd[c] > VDG)), "R10 fast_pd vs model",
                    fast_pd[c], (m_core > CDG) || (m_vdd[c] > VDG));
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        started = 1;
        cyc(1);
        // R11: reset state
        chk(gate_on == 0 && pgood == 0 && fast_pd == 0 && ch_fault == 0, "R11 reset outputs",
            {gate_on, pgood, fast_pd, ch_fault}, 0);

        // R1/R2: start-up, then power good
        ch_on[0] = 1; cyc(3);
        chk(gate_on[0] == 1, "R1 gate after on", gate_on[0], 1);
        cyc(15);
        chk(pgood[0] == 0, "R2 no pgood without fb", pgood[0], 0);
        ch_fb_ok[0] = 1; ch_gate_enh[0] = 1; cyc(3);
        chk(pgood[0] == 1, "R2 pgood qualified", pgood[0], 1);

        // R3: on low; pgood holds until fb drops
        ch_on[0] = 0; cyc(2);
        chk(gate_on[0] == 0, "R3 on low turns off", gate_on[0], 0);
        chk(pgood[0] == 1, "R2 pgood held by fb", pgood[0], 1);
        ch_fb_ok[0] = 0; cyc(2);
        chk(pgood[0] == 0, "R2 pgood clears on fb low", pgood[0], 0);
        ch_fb_ok[0] = 1; ch_on[0] = 1; cyc(15);

        // R3: software enable cleared, then restored
        wr(2'd0, 4'h6); cyc(2);
        chk(gate_on[0] == 0, "R3 sw enable off", gate_on[0], 0);
        wr(2'd0, 4'h7); cyc(15);

        // R4: UV and OV turn off, record bits; retry lets restart (R7)
        ch_uv[0] = 1; cyc(2);
        chk(gate_on[0] == 0 && ch_fault[0] == 1, "R4 uv off and bit0", {gate_on[0], ch_fault[0]}, 1);
        ch_uv[0] = 0; cyc(3);
        chk(gate_on[0] == 1, "R7 uv retry restarts", gate_on[0], 1);
        ch_ov[0] = 1; cyc(2);
        chk(gate_on[0] == 0 && ch_fault[1] == 1, "R4 ov off and bit1", {gate_on[0], ch_fault[1]}, 1);
        ch_ov[0] = 0; cyc(15);

        // R4: detach rising edge
        ch_detach[0] = 1; cyc(2);
        chk(gate_on[0] == 0, "R4 detach edge off", gate_on[0], 0);
        ch_detach[0] = 0; cyc(15);

        // R9: on falling edge clears faults
        chk(ch_fault[2:0] == 3'b011, "R9 faults before on-fall", ch_fault[2:0], 3);
        ch_on[0] = 0; cyc(2);
        chk(ch_fault[2:0] == 0, "R9 on-fall clears", ch_fault[2:0], 0);

        // R5: current limit at expiry -> OC, latched (R7)
        ch_ilim[0] = 1; ch_on[0] = 1; cyc(15);
        chk(ch_fault[2] == 1 && gate_on[0] == 0, "R5 oc at expiry", {ch_fault[2], gate_on[0]}, 2);
        cyc(10);
        chk(gate_on[0] == 0, "R7 oc latched off", gate_on[0], 0);
        ch_on[0] = 0; cyc(2);
        chk(ch_fault[2:0] == 0, "R9 on-fall clears oc", ch_fault[2:0], 0);
        ch_on[0] = 1; cyc(4);
        ch_ilim[0] = 0; cyc(12);
        chk(gate_on[0] == 1 && ch_fault[2:0] == 0, "R5 early clear no fault",
            {gate_on[0], ch_fault[2:0]}, 8);

        // R6: dual mode couples overcurrent
        ch_on[1] = 1; ch_fb_ok[1] = 1; ch_gate_enh[1] = 1; cyc(15);
        oc_single_mode = 0;
        ch_ilim[1] = 1; cyc(2);
        ch_ilim[1] = 0; cyc(20);
        chk(gate_on == 2'b00, "R6 both off on oc", gate_on, 0);
        chk(ch_fault[5] == 1 && ch_fault[2] == 0, "R6 only faulting bit", {ch_fault[5], ch_fault[2]}, 2);
        wr(2'd3, 4'h0); cyc(15);
        chk(gate_on == 2'b11, "R8 clear restarts both", gate_on, 3);
        oc_single_mode = 1;

        // R8: software fault write latches per retry
        wr(2'd1, 4'h4); cyc(3);
        chk(gate_on[0] == 0 && gate_on[1] == 1, "R8 write oc latches", gate_on, 2);
        wr(2'd1, 4'h0); cyc(15);
        chk(gate_on[0] == 1, "R8 write zero restarts", gate_on[0], 1);
        wr(2'd0, 4'hF); wr(2'd1, 4'h4); cyc(3);
        chk(gate_on[0] == 1, "R7 retry set no latch", gate_on[0], 1);
        wr(2'd1, 4'h0); wr(2'd0, 4'h7); cyc(3);

        // R1: tick-counted start-up
        tmr_fixed_sel = 0;
        ch_on[1] = 0; cyc(2);
        ch_on[1] = 1; cyc(20);
        chk(gate_on[1] == 1 && pgood[1] == 0, "R1 waits for ticks", {gate_on[1], pgood[1]}, 2);
        for (int k = 0; k < 5; k++) begin
            tmr_tick = 1; cyc(1); tmr_tick = 0; cyc(1);
        end
        cyc(2);
        chk(pgood[1] == 1, "R1 tick expiry pgood", pgood[1], 1);
        tmr_fixed_sel = 1;

        // R10: supply dips
        vdd_ok[0] = 0; cyc(3);
        chk(fast_pd[0] == 0 && gate_on[0] == 1, "R10 short dip ignored", {fast_pd[0], gate_on[0]}, 1);
        vdd_ok[0] = 1; cyc(2);
        vdd_ok[0] = 0; cyc(8);
        chk(fast_pd == 2'b01 && gate_on == 2'b10, "R10 vdd trip one channel", {fast_pd, gate_on}, 6);
        vdd_ok[0] = 1; cyc(15);
        core_ok = 0; cyc(6);
        chk(fast_pd == 2'b11 && gate_on == 2'b00, "R10 core trip both", {fast_pd, gate_on}, 12);
        core_ok = 1; cyc(15);
        chk(gate_on == 2'b11, "R10 recovery", gate_on, 3);

        cyc(2);
        finish_run();
    end
endmodule